// File: doc/BRIEF.md
# Audio Event Interrupt Aggregator

This block collects per-port event pulses from the audio subsystem and folds them into a single interrupt request for the host processor. There are five source banks. Three cover playback ports: FIFO underflow, ring underflow and the free-space threshold. Two cover capture ports: ring overflow and the fill threshold. In every bank, bit n belongs to port n. A bank latches its events into a status register and forwards only the bits its mask leaves open. A second-level summary register holds one bit per bank. The summary has its own mask, and it drives the interrupt output.

Software reads the status and masks, and changes them through write-one strobes, over a simple word-addressed register bus. Reads are combinational. The two threshold sources are one-shot per port. After a threshold crossing has been latched, later crossings on that port are ignored until software writes a one to that port's bit in the matching rearm register.

Address map. The word address is `{group[2:0], slot[2:0]}`. Groups 0 to 4 are the source banks, in this order: 0 playback FIFO underflow, 1 playback ring underflow, 2 capture ring overflow, 3 playback free threshold, 4 capture fill threshold. Group 5 is the summary. Within groups 0 to 5 the slots are: 0 status (read), 1 status clear (write one), 2 mask (read), 3 mask set (write one), 4 mask clear (write one). Group 6 holds the rearm registers: slot 0 rearms the playback threshold ports and slot 1 rearms the capture threshold ports. Summary bit i corresponds to bank i.

Top module: `aud_irq_ctrl`

## Requirements
- R1: Only status (slot 0) and mask (slot 2) of groups 0 to 5 return data on read; every other address reads zero. Writes to slot 0 or slot 2 change nothing.
- R2: An event on port n of a bank sets status bit n of that bank on the next clock, whatever the mask says. Capture banks (2 and 4) have 3 bits and playback banks have 4; bits above a bank's width read zero.
- R3: Writing one to a bit in a bank's status clear slot clears that bit. If an event on the same bit arrives in the same cycle, the bit stays set.
- R4: Writing ones to a bank's mask set slot sets those mask bits, and writing ones to its mask clear slot clears them. A set mask bit blocks that status bit from the summary.
- R5: A threshold crossing (banks 3 and 4) sets its status bit only while its port is armed, and the crossing disarms that port. While the port is disarmed, crossings set nothing.
- R6: Writing one to a port's bit at address 48 (playback threshold) or 49 (capture threshold) rearms that port. The rearm takes effect for crossings from the next cycle on.
- R7: Summary bit i is set on the clock after bank i holds any status bit with a clear mask bit. Writing one to the summary clear address (41) clears that summary bit. If the bank is still pending at that moment, the bit stays set.
- R8: The summary mask is set and cleared through addresses 43 and 44. The interrupt output is high when any summary bit is set and its summary mask bit is clear.
- R9: After reset, all status and summary bits are zero. All bank masks are all ones over the bank width, the summary mask is 5'h1F, every threshold port is armed, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Word address {group, slot} |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Combinational read data for bus_addr_i |
| play_fifo_uflow_i | input | PLAY_PORTS | Playback FIFO underflow events |
| play_ring_uflow_i | input | PLAY_PORTS | Playback ring underflow events |
| cap_ring_oflow_i | input | CAP_PORTS | Capture ring overflow events |
| play_free_cross_i | input | PLAY_PORTS | Playback free-space threshold crossings |
| cap_full_cross_i | input | CAP_PORTS | Capture fill threshold crossings |
| irq_o | output | 1 | Summary interrupt request |

## Verification
The bench goes after four corner cases.

- An event and a status clear on the same bit in the same cycle. A design that let the clear win would lose an underflow that software never saw.
- A masked event. A design that gated latching with the mask would read zero status; one that forwarded regardless of the mask would raise the interrupt.
- Repeated threshold crossings on a disarmed port, followed by a rearm. A design without the one-shot arm would flood the status bit; one whose rearm failed would never report that port again.
- Clearing the summary while its bank is still pending, and the one-cycle delay between status and summary. A wrong design would drop the summary bit or raise the interrupt a cycle early.

// File: rtl/aud_irq_pkg.sv
// Package: shared constants for the audio event interrupt aggregator.
// Assumes a 6-bit word address split into a 3-bit group and a 3-bit slot.
package aud_irq_pkg;
    localparam int NUM_BANKS = 5;
    localparam int ADDR_W    = 6;

    // Source bank indices; the order is also the summary bit order.
    localparam int BANK_PLAY_FIFO = 0;
    localparam int BANK_PLAY_RING = 1;
    localparam int BANK_CAP_RING  = 2;
    localparam int BANK_PLAY_FREE = 3;
    localparam int BANK_CAP_FULL  = 4;

    // Register slots inside a group.
    localparam logic [2:0] SLOT_STAT     = 3'd0;
    localparam logic [2:0] SLOT_STAT_CLR = 3'd1;
    localparam logic [2:0] SLOT_MASK     = 3'd2;
    localparam logic [2:0] SLOT_MASK_SET = 3'd3;
    localparam logic [2:0] SLOT_MASK_CLR = 3'd4;

    // Groups beyond the source banks.
    localparam logic [2:0] GRP_SUMMARY = 3'd5;
    localparam logic [2:0] GRP_REARM   = 3'd6;
    localparam logic [2:0] SLOT_REARM_PLAY = 3'd0;
    localparam logic [2:0] SLOT_REARM_CAP  = 3'd1;
endpackage

// File: rtl/aud_irq_bank.sv
// Module: one status/mask bank.
// Latches event bits regardless of the mask. Clear is write-one.
// An event in the same cycle as a clear keeps the bit set.
// Masks reset to all ones. pending_o flags any unmasked status bit.
// Assumes set and clear strobes are one-cycle pulses from the bus decoder.
module aud_irq_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_stb_i,
    input  logic         mset_stb_i,
    input  logic         mclr_stb_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] mask_o,
    output logic         pending_o
);
    logic [W-1:0] clr_bits;

    // Bits cleared this cycle by a status clear write.
    assign clr_bits = clr_stb_i ? wdata_i : '0;

    // Status latch: events override clears.
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (status_o & ~clr_bits) | evt_i;
    end

    // Mask register with write-one set and write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)          mask_o <= '1;
        else if (mset_stb_i) mask_o <= mask_o | wdata_i;
        else if (mclr_stb_i) mask_o <= mask_o & ~wdata_i;
    end

    // Any unmasked status bit marks the bank as pending.
    assign pending_o = |(status_o & ~mask_o);
endmodule

// File: rtl/aud_mark_arm.sv
// Module: per-port one-shot gate for threshold crossings.
// A crossing passes only while its port is armed and then disarms the port.
// A write-one rearm sets the port armed again from the next cycle.
// Ports reset armed.
module aud_mark_arm #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cross_i,
    input  logic         rearm_stb_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] fire_o,
    output logic [W-1:0] armed_o
);
    // Arm state: a crossing disarms, a rearm write arms.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_o <= '1;
        else        armed_o <= (armed_o & ~cross_i) | (rearm_stb_i ? wdata_i : '0);
    end

    // Forward crossings of armed ports only.
    assign fire_o = cross_i & armed_o;
endmodule

// File: rtl/aud_irq_ctrl.sv
// Module: two-level audio event interrupt aggregator (top).
// Five source banks feed a summary bank, and the summary drives irq_o.
// Register access uses a word-addressed bus with combinational reads.
// Assumes PLAY_PORTS >= CAP_PORTS and DATA_W >= both port counts and >= 5.
module aud_irq_ctrl
    import aud_irq_pkg::*;
#(
    parameter int PLAY_PORTS = 4,
    parameter int CAP_PORTS  = 3,
    parameter int DATA_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we_i,
    input  logic [ADDR_W-1:0]     bus_addr_i,
    input  logic [DATA_W-1:0]     bus_wdata_i,
    output logic [DATA_W-1:0]     bus_rdata_o,
    input  logic [PLAY_PORTS-1:0] play_fifo_uflow_i,
    input  logic [PLAY_PORTS-1:0] play_ring_uflow_i,
    input  logic [CAP_PORTS-1:0]  cap_ring_oflow_i,
    input  logic [PLAY_PORTS-1:0] play_free_cross_i,
    input  logic [CAP_PORTS-1:0]  cap_full_cross_i,
    output logic                  irq_o
);
    localparam int PW = (PLAY_PORTS > CAP_PORTS) ? PLAY_PORTS : CAP_PORTS;

    logic [2:0]             grp, slot;
    logic [NUM_BANKS:0]     clr_stb, mset_stb, mclr_stb;
    logic                   rearm_play, rearm_cap;
    logic [PLAY_PORTS-1:0]  free_fire, free_armed;
    logic [CAP_PORTS-1:0]   full_fire, full_armed;
    logic [PW-1:0]          bank_evt [NUM_BANKS];
    logic [PW-1:0]          bank_st  [NUM_BANKS];
    logic [PW-1:0]          bank_mk  [NUM_BANKS];
    logic [NUM_BANKS-1:0]   bank_pend;
    logic [NUM_BANKS-1:0]   sum_st, sum_mk;
    logic [NUM_BANKS*PW-1:0] st_flat, mk_flat;

    assign grp  = bus_addr_i[5:3];
    assign slot = bus_addr_i[2:0];

    // Write strobe decode for the bank and summary groups.
    always_comb begin
        for (int g = 0; g <= NUM_BANKS; g++) begin
            clr_stb[g]  = bus_we_i && (grp == 3'(g)) && (slot == SLOT_STAT_CLR);
            mset_stb[g] = bus_we_i && (grp == 3'(g)) && (slot == SLOT_MASK_SET);
            mclr_stb[g] = bus_we_i && (grp == 3'(g)) && (slot == SLOT_MASK_CLR);
        end
    end

    // Rearm strobe decode.
    assign rearm_play = bus_we_i && (grp == GRP_REARM) && (slot == SLOT_REARM_PLAY);
    assign rearm_cap  = bus_we_i && (grp == GRP_REARM) && (slot == SLOT_REARM_CAP);

    aud_mark_arm #(.W(PLAY_PORTS)) u_free_arm (
        .clk, .rst_n,
        .cross_i(play_free_cross_i), .rearm_stb_i(rearm_play),
        .wdata_i(bus_wdata_i[PLAY_PORTS-1:0]),
        .fire_o(free_fire), .armed_o(free_armed)
    );

    aud_mark_arm #(.W(CAP_PORTS)) u_full_arm (
        .clk, .rst_n,
        .cross_i(cap_full_cross_i), .rearm_stb_i(rearm_cap),
        .wdata_i(bus_wdata_i[CAP_PORTS-1:0]),
        .fire_o(full_fire), .armed_o(full_armed)
    );

    // Route each event source into its bank slot.
    always_comb begin
        bank_evt[BANK_PLAY_FIFO] = PW'(play_fifo_uflow_i);
        bank_evt[BANK_PLAY_RING] = PW'(play_ring_uflow_i);
        bank_evt[BANK_CAP_RING]  = PW'(cap_ring_oflow_i);
        bank_evt[BANK_PLAY_FREE] = PW'(free_fire);
        bank_evt[BANK_CAP_FULL]  = PW'(full_fire);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int BW = (b == BANK_CAP_RING || b == BANK_CAP_FULL) ? CAP_PORTS : PLAY_PORTS;
        logic [BW-1:0] st, mk;
        aud_irq_bank #(.W(BW)) u_bank (
            .clk, .rst_n,
            .evt_i(bank_evt[b][BW-1:0]),
            .clr_stb_i(clr_stb[b]), .mset_stb_i(mset_stb[b]), .mclr_stb_i(mclr_stb[b]),
            .wdata_i(bus_wdata_i[BW-1:0]),
            .status_o(st), .mask_o(mk), .pending_o(bank_pend[b])
        );
        assign bank_st[b] = PW'(st);
        assign bank_mk[b] = PW'(mk);
        assign st_flat[b*PW +: PW] = bank_st[b];
        assign mk_flat[b*PW +: PW] = bank_mk[b];
    end

    // Second level: one summary bit per bank, pending bit drives the interrupt.
    aud_irq_bank #(.W(NUM_BANKS)) u_summary (
        .clk, .rst_n,
        .evt_i(bank_pend),
        .clr_stb_i(clr_stb[NUM_BANKS]), .mset_stb_i(mset_stb[NUM_BANKS]),
        .mclr_stb_i(mclr_stb[NUM_BANKS]),
        .wdata_i(bus_wdata_i[NUM_BANKS-1:0]),
        .status_o(sum_st), .mask_o(sum_mk), .pending_o(irq_o)
    );

    // Combinational read mux; unmapped addresses return zero.
    always_comb begin
        bus_rdata_o = '0;
        for (int g = 0; g < NUM_BANKS; g++) begin
            if (grp == 3'(g)) begin
                if (slot == SLOT_STAT)      bus_rdata_o = DATA_W'(bank_st[g]);
                else if (slot == SLOT_MASK) bus_rdata_o = DATA_W'(bank_mk[g]);
            end
        end
        if (grp == GRP_SUMMARY) begin
            if (slot == SLOT_STAT)      bus_rdata_o = DATA_W'(sum_st);
            else if (slot == SLOT_MASK) bus_rdata_o = DATA_W'(sum_mk);
        end
    end
endmodule

// File: rtl/aud_irq_ctrl_chk.sv
// Module: assertion checker bound to aud_irq_ctrl.
// It watches latched state against bus writes and events over time.
module aud_irq_ctrl_chk #(
    parameter int PLAY_PORTS = 4,
    parameter int CAP_PORTS  = 3,
    parameter int NB         = 5,
    parameter int PW         = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_we_i,
    input logic                  irq_o,
    input logic [PLAY_PORTS-1:0] play_fifo_uflow_i,
    input logic [NB*PW-1:0]      st_flat,
    input logic [NB*PW-1:0]      mk_flat,
    input logic [NB-1:0]         sum_st,
    input logic [NB-1:0]         sum_mk,
    input logic [PLAY_PORTS-1:0] free_armed,
    input logic [CAP_PORTS-1:0]  full_armed
);
    logic [PLAY_PORTS-1:0] fifo_st, free_st;
    assign fifo_st = st_flat[PLAY_PORTS-1:0];
    assign free_st = st_flat[3*PW +: PLAY_PORTS];

    // R2
    fifo_evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (play_fifo_uflow_i != '0) |=> ((fifo_st & $past(play_fifo_uflow_i)) == $past(play_fifo_uflow_i)));

    // R3
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_i |=> ((st_flat & $past(st_flat)) == $past(st_flat)));

    // R4
    mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_i |=> ($stable(mk_flat) && $stable(sum_mk)));

    // R5
    disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_armed != '1) |=> ((free_st & ~$past(free_st) & ~$past(free_armed)) == '0));

    // R6
    arm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_i |=> (((free_armed & ~$past(free_armed)) == '0) &&
                       ((full_armed & ~$past(full_armed)) == '0)));

    // R7
    summary_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_i |=> ((sum_st & $past(sum_st)) == $past(sum_st)));

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (sum_st != '0));
endmodule

bind aud_irq_ctrl aud_irq_ctrl_chk #(
    .PLAY_PORTS(PLAY_PORTS), .CAP_PORTS(CAP_PORTS), .NB(aud_irq_pkg::NUM_BANKS), .PW(PW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we_i(bus_we_i), .irq_o(irq_o),
    .play_fifo_uflow_i(play_fifo_uflow_i),
    .st_flat(st_flat), .mk_flat(mk_flat), .sum_st(sum_st), .sum_mk(sum_mk),
    .free_armed(free_armed), .full_armed(full_armed)
);

// File: tb/aud_irq_ctrl_tb_top.sv
`timescale 1ns/100ps
module aud_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pf = '0, pr = '0, fm = '0;
    logic [2:0]  co = '0, cf = '0;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state built from the requirements.
    logic [3:0] m_st [5];
    logic [3:0] m_mk [5];
    logic [4:0] m_sum, m_smk;
    logic [3:0] m_farm;
    logic [2:0] m_carm;

    always #2.5 clk = ~clk;

    aud_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .play_fifo_uflow_i(pf), .play_ring_uflow_i(pr), .cap_ring_oflow_i(co),
        .play_free_cross_i(fm), .cap_full_cross_i(cf), .irq_o(irq)
    );

    function automatic logic [3:0] wmask(int b);
        return (b == 2 || b == 4) ? 4'h7 : 4'hF;
    endfunction

    task automatic model_reset();
        for (int b = 0; b < 5; b++) begin
            m_st[b] = '0;
            m_mk[b] = wmask(b);
        end
        m_sum = '0; m_smk = 5'h1F; m_farm = 4'hF; m_carm = 3'h7;
    endtask

    // Next state from the currently driven inputs.
    task automatic model_step();
        logic [4:0] pend;
        logic [3:0] ev [5];
        logic [3:0] clr;
        logic [4:0] sclr;
        logic [2:0] g, s;
        g = addr[5:3]; s = addr[2:0];
        for (int b = 0; b < 5; b++) pend[b] = |(m_st[b] & ~m_mk[b]);
        ev[0] = pf; ev[1] = pr; ev[2] = {1'b0, co};
        ev[3] = fm & m_farm; ev[4] = {1'b0, cf & m_carm};
        for (int b = 0; b < 5; b++) begin
            clr = (we && g == 3'(b) && s == 3'd1) ? (wdata[3:0] & wmask(b)) : 4'h0;
            m_st[b] = (m_st[b] & ~clr) | (ev[b] & wmask(b));
            if (we && g == 3'(b) && s == 3'd3)      m_mk[b] = m_mk[b] | (wdata[3:0] & wmask(b));
            else if (we && g == 3'(b) && s == 3'd4) m_mk[b] = m_mk[b] & ~(wdata[3:0] & wmask(b));
        end
        sclr = (we && g == 3'd5 && s == 3'd1) ? wdata[4:0] : 5'h0;
        m_sum = (m_sum & ~sclr) | pend;
        if (we && g == 3'd5 && s == 3'd3)      m_smk = m_smk | wdata[4:0];
        else if (we && g == 3'd5 && s == 3'd4) m_smk = m_smk & ~wdata[4:0];
        m_farm = (m_farm & ~fm) | ((we && addr == 6'd48) ? wdata[3:0] : 4'h0);
        m_carm = (m_carm & ~cf) | ((we && addr == 6'd49) ? wdata[2:0] : 3'h0);
    endtask

    function automatic logic [31:0] exp_rd(logic [5:0] a);
        if (a[5:3] < 3'd5 && a[2:0] == 3'd0) return 32'(m_st[a[5:3]]);
        if (a[5:3] < 3'd5 && a[2:0] == 3'd2) return 32'(m_mk[a[5:3]]);
        if (a == 6'd40) return 32'(m_sum);
        if (a == 6'd42) return 32'(m_smk);
        return 32'h0;
    endfunction

    function automatic string lbl(logic [5:0] a);
        if (a[5:3] < 3'd5) return (a[2:0] == 3'd0) ? "R2" : "R4";
        return (a[2:0] == 3'd0) ? "R7" : "R8";
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%0d actual=0x%0h expected=0x%0h", req, addr, act, exp);
        end
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] v);
        addr = a;
        #0.1;
        v = rdata;
    endtask

    task automatic idle_inputs();
        we = 1'b0; wdata = '0; pf = '0; pr = '0; co = '0; fm = '0; cf = '0;
    endtask

    // Advance one clock with the driven stimulus; return at the next falling edge.
    task automatic tick();
        if (rst_n) model_step(); else model_reset();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    // Compare every readable register and the interrupt against the model.
    task automatic sweep();
        logic [31:0] v;
        for (int b = 0; b < 6; b++) begin
            rd(6'(b * 8), v);     chk(lbl(6'(b * 8)), v, exp_rd(6'(b * 8)));
            rd(6'(b * 8 + 2), v); chk(lbl(6'(b * 8 + 2)), v, exp_rd(6'(b * 8 + 2)));
        end
        chk("R8", 32'(irq), 32'(|(m_sum & ~m_smk)));
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int seed_dummy;
        seed_dummy = $urandom(32'd5150);
        model_reset();
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;

        // R9: reset values
        rd(6'd0, v);  chk("R9", v, 32'h0);
        rd(6'd2, v);  chk("R9", v, 32'hF);
        rd(6'd18, v); chk("R9", v, 32'h7);
        rd(6'd40, v); chk("R9", v, 32'h0);
        rd(6'd42, v); chk("R9", v, 32'h1F);
        chk("R9", 32'(irq), 32'h0);

        // R2: masked event on port 2 still latches, no interrupt
        pf = 4'b0100; tick();
        rd(6'd0, v); chk("R2", v, 32'h4);
        tick();
        rd(6'd40, v); chk("R4", v, 32'h0);
        chk("R4", 32'(irq), 32'h0);

        // R3: clear and event on the same bit; event wins, then plain clear
        wr(6'd1, 32'h4); pf = 4'b0100; tick();
        rd(6'd0, v); chk("R3", v, 32'h4);
        wr(6'd1, 32'h4); tick();
        rd(6'd0, v); chk("R3", v, 32'h0);

        // R1: writes to read-only slots are ignored; unmapped reads are zero
        wr(6'd0, 32'hF); tick();
        wr(6'd2, 32'h0); tick();
        rd(6'd0, v);  chk("R1", v, 32'h0);
        rd(6'd2, v);  chk("R1", v, 32'hF);
        rd(6'd7, v);  chk("R1", v, 32'h0);
        rd(6'd56, v); chk("R1", v, 32'h0);
        rd(6'd1, v);  chk("R1", v, 32'h0);

        // R5: first crossing latches, later crossings on a disarmed port do not
        fm = 4'b0010; tick();
        rd(6'd24, v); chk("R5", v, 32'h2);
        wr(6'd25, 32'h2); tick();
        fm = 4'b0010; tick();
        rd(6'd24, v); chk("R5", v, 32'h0);
        cf = 3'b100; tick();
        cf = 3'b100; wr(6'd33, 32'h4); tick();
        rd(6'd32, v); chk("R5", v, 32'h0);

        // R6: rearm, then the next crossing latches again
        wr(6'd48, 32'h2); tick();
        fm = 4'b0010; tick();
        rd(6'd24, v); chk("R6", v, 32'h2);
        wr(6'd49, 32'h4); tick();
        cf = 3'b100; tick();
        rd(6'd32, v); chk("R6", v, 32'h4);

        // R7/R8: one-cycle summary delay, sticky summary while still pending
        wr(6'd4, 32'h1); tick();
        wr(6'd44, 32'h1); tick();
        pf = 4'b0001; tick();
        rd(6'd0, v); chk("R7", v, 32'h1);
        chk("R7", 32'(irq), 32'h0);
        tick();
        rd(6'd40, v); chk("R7", v, 32'h1);
        chk("R8", 32'(irq), 32'h1);
        wr(6'd41, 32'h1); tick();
        rd(6'd40, v); chk("R7", v, 32'h1);
        wr(6'd1, 32'h1); tick();
        wr(6'd41, 32'h1); tick();
        rd(6'd40, v); chk("R7", v, 32'h0);
        chk("R8", 32'(irq), 32'h0);
        wr(6'd43, 32'h1); tick();
        rd(6'd42, v); chk("R8", v, 32'h1F);
        sweep();

        // Random phase checked against the reference state every cycle
        for (int i = 0; i < 3000; i++) begin
            pf = 4'($urandom) & 4'($urandom) & 4'($urandom);
            pr = 4'($urandom) & 4'($urandom) & 4'($urandom);
            co = 3'($urandom) & 3'($urandom) & 3'($urandom);
            fm = 4'($urandom) & 4'($urandom);
            cf = 3'($urandom) & 3'($urandom);
            if ($urandom_range(0, 2) == 0) begin
                int pick;
                pick = $urandom_range(0, 9);
                if (pick < 7)       wr(6'($urandom_range(0, 5) * 8 + $urandom_range(0, 4)), $urandom);
                else if (pick == 7) wr(6'(48 + $urandom_range(0, 1)), $urandom);
                else                wr(6'($urandom), $urandom);
            end
            tick();
            sweep();
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule